// File: doc/BRIEF.md
# Dual-Issue Breakpoint Resolver

This block sits at the retire stage of a pipeline that can retire two instructions in one cycle, an older slot A and a younger slot B. An address comparator outside the block tags each slot with two match flags: one asking to stop before the instruction executes, one asking to stop after it. Each cycle the resolver merges the four flags into a single verdict. The verdict says whether the machine stops before the pair, stops after it, or both, and which slots may retire.

After a halt the block stays halted until a resume strobe arrives. When the halt was a stop-before, the before-match on the restart instruction is masked for a fixed number of issues, so execution can step off that breakpoint. A stop-before request on B that is still pending is kept. The pair is then split: A retires alone and the machine stops in front of B. This way a breakpoint on the second of two adjacent instructions still fires after the first one has been resumed.

Top module: `dual_brk_resolver`

## Requirements
- R1: After reset the block is running: `halted` is 0, and without issue no output is raised.
- R2: For a dual issue with no active resume mask, a stop-before flag on A or on B raises `halt_pre`, and neither slot commits.
- R3: For a dual issue, a stop-after flag on A or on B raises `halt_post`. When no stop-before flag is set, both slots commit in that cycle.
- R4: For a dual issue, a stop-before flag on one slot together with a stop-after flag on the other slot, in either order, raises both `halt_pre` and `halt_post`.
- R5: When `issue_solo` is 1, only A issues and the B flags have no effect. A stop-before flag on A raises `halt_pre` and blocks A. A stop-after flag on A raises `halt_post` only when A commits.
- R6: A cycle with `halt_pre` or `halt_post` sets `halted` from the next cycle on. While the block is halted, issues produce no commit and no halt output.
- R7: `resume` while halted returns the block to running in the next cycle. `resume` while running has no effect.
- R8: After resuming from a halt that raised `halt_pre`, the A stop-before flag is ignored for MASK_ISSUES issues (default 1). After a halt that raised only `halt_post`, nothing is masked.
- R9: While the resume mask is active, a dual issue with a stop-before flag on B commits A only. It raises `halt_pre` (stop in front of B), and it raises `halt_post` exactly when A carries a stop-after flag.
- R10: Without `issue_vld`, the block raises no commit and no halt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_vld | input | 1 | An issue is presented this cycle |
| issue_solo | input | 1 | Only slot A issues |
| brk_pre_a | input | 1 | Stop-before match on slot A |
| brk_post_a | input | 1 | Stop-after match on slot A |
| brk_pre_b | input | 1 | Stop-before match on slot B |
| brk_post_b | input | 1 | Stop-after match on slot B |
| resume | input | 1 | Restart strobe from the debug side |
| halt_pre | output | 1 | Stop before the oldest uncommitted instruction |
| halt_post | output | 1 | Stop after the committed instructions |
| commit_a | output | 1 | Slot A retires |
| commit_b | output | 1 | Slot B retires |
| halted | output | 1 | Block is in the halted state |

## Verification
All sixteen combinations of the four match flags are applied in both dual and solo issue. Each one starts from reset and is repeated over several resume rounds. The first round tells the plain merge rules apart: before-only, after-only, mixed, and none. The later rounds run with the resume mask active and then expired, which separates masking from splitting and shows that the mask lasts only one issue. Issues presented while halted, a resume given while running, and idle cycles confirm that these cases have no effect.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int NSLOT = 2;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HALT = 1'b1
  } dbr_state_e;

  typedef struct packed {
    logic pre;
    logic post;
  } dbr_req_t;

  typedef struct packed {
    logic halt_pre;
    logic halt_post;
    logic commit_a;
    logic commit_b;
  } dbr_verdict_t;
endpackage

// File: rtl/dbr_slot_gate.sv
module dbr_slot_gate
  import dbr_pkg::*;
(
  input  logic                   skip_act,
  input  logic [NSLOT-1:0]       slot_vld,
  input  dbr_req_t [NSLOT-1:0]   raw,
  output dbr_req_t [NSLOT-1:0]   eff
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (i == 0) begin : g_head
      // restart slot: before-match masked while the resume mask is live
      assign eff[i].pre  = raw[i].pre & slot_vld[i] & ~skip_act;
    end else begin : g_tail
      assign eff[i].pre  = raw[i].pre & slot_vld[i];
    end
    assign eff[i].post = raw[i].post & slot_vld[i];
  end
endmodule

// File: rtl/dbr_merge.sv
module dbr_merge
  import dbr_pkg::*;
(
  input  logic         vld_a,
  input  logic         vld_b,
  input  logic         skip_act,
  input  dbr_req_t     eff_a,
  input  dbr_req_t     eff_b,
  output dbr_verdict_t verdict
);
  logic split;

  assign split = skip_act & vld_b & eff_b.pre;

  always_comb begin
    verdict = '0;
    if (!vld_a) begin
      verdict = '0;
    end else if (!vld_b) begin
      // single issue: A's own flags apply directly
      verdict.halt_pre  = eff_a.pre;
      verdict.halt_post = eff_a.post & ~eff_a.pre;
      verdict.commit_a  = ~eff_a.pre;
      verdict.commit_b  = 1'b0;
    end else if (split) begin
      // leaving a breakpoint with one still pending on B
      verdict.halt_pre  = 1'b1;
      verdict.halt_post = eff_a.post;
      verdict.commit_a  = 1'b1;
      verdict.commit_b  = 1'b0;
    end else begin
      // pair merge: any before-match stops ahead of A, any after-match behind B
      verdict.halt_pre  = eff_a.pre | eff_b.pre;
      verdict.halt_post = eff_a.post | eff_b.post;
      verdict.commit_a  = ~(eff_a.pre | eff_b.pre);
      verdict.commit_b  = ~(eff_a.pre | eff_b.pre);
    end
  end
endmodule

// File: rtl/dbr_seq.sv
module dbr_seq
  import dbr_pkg::*;
#(
  parameter int MASK_ISSUES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue_go,
  input  logic resume,
  input  logic ev_pre,
  input  logic ev_post,
  output logic halted,
  output logic skip_act
);
  localparam int CW = $clog2(MASK_ISSUES + 1);
  localparam logic [CW-1:0] MASK_LOAD = CW'(MASK_ISSUES);

  dbr_state_e    st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          pre_q, pre_n;
  logic          upd;

  assign halted   = (st_q == ST_HALT);
  assign skip_act = (cnt_q != '0);

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    pre_n = pre_q;
    upd   = 1'b0;
    case (st_q)
      ST_RUN: begin
        if (issue_go) begin
          upd = 1'b1;
          if (skip_act) cnt_n = cnt_q - CW'(1);
          if (ev_pre || ev_post) begin
            st_n  = ST_HALT;
            pre_n = ev_pre;
            cnt_n = '0;
          end
        end
      end
      ST_HALT: begin
        if (resume) begin
          upd   = 1'b1;
          st_n  = ST_RUN;
          cnt_n = pre_q ? MASK_LOAD : '0;
        end
      end
      default: begin
        upd  = 1'b1;
        st_n = ST_RUN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RUN;
      cnt_q <= '0;
      pre_q <= 1'b0;
    end else if (upd) begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      pre_q <= pre_n;
    end
  end
endmodule

// File: rtl/dual_brk_resolver.sv
module dual_brk_resolver
  import dbr_pkg::*;
#(
  parameter int MASK_ISSUES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue_vld,
  input  logic issue_solo,
  input  logic brk_pre_a,
  input  logic brk_post_a,
  input  logic brk_pre_b,
  input  logic brk_post_b,
  input  logic resume,
  output logic halt_pre,
  output logic halt_post,
  output logic commit_a,
  output logic commit_b,
  output logic halted
);
  logic                 halted_q;
  logic                 skip_act;
  logic                 issue_go;
  logic [NSLOT-1:0]     slot_vld;
  dbr_req_t [NSLOT-1:0] raw;
  dbr_req_t [NSLOT-1:0] eff;
  dbr_verdict_t         verdict;

  assign issue_go    = issue_vld & ~halted_q;
  assign slot_vld[0] = issue_go;
  assign slot_vld[1] = issue_go & ~issue_solo;

  assign raw[0].pre  = brk_pre_a;
  assign raw[0].post = brk_post_a;
  assign raw[1].pre  = brk_pre_b;
  assign raw[1].post = brk_post_b;

  dbr_slot_gate u_gate (
    .skip_act (skip_act),
    .slot_vld (slot_vld),
    .raw      (raw),
    .eff      (eff)
  );

  dbr_merge u_merge (
    .vld_a    (slot_vld[0]),
    .vld_b    (slot_vld[1]),
    .skip_act (skip_act),
    .eff_a    (eff[0]),
    .eff_b    (eff[1]),
    .verdict  (verdict)
  );

  dbr_seq #(.MASK_ISSUES(MASK_ISSUES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue_go (issue_go),
    .resume   (resume),
    .ev_pre   (verdict.halt_pre),
    .ev_post  (verdict.halt_post),
    .halted   (halted_q),
    .skip_act (skip_act)
  );

  assign halt_pre  = verdict.halt_pre;
  assign halt_post = verdict.halt_post;
  assign commit_a  = verdict.commit_a;
  assign commit_b  = verdict.commit_b;
  assign halted    = halted_q;
endmodule

// File: rtl/dbr_checker.sv
module dbr_checker (
  input logic clk,
  input logic rst_n,
  input logic issue_vld,
  input logic issue_solo,
  input logic resume,
  input logic halt_pre,
  input logic halt_post,
  input logic commit_a,
  input logic commit_b,
  input logic halted
);
  p_pre_blocks_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    halt_pre |-> !commit_b);

  p_solo_no_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_solo |-> !commit_b);

  p_halt_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_pre || halt_post) |=> halted);

  p_halted_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!commit_a && !commit_b && !halt_pre && !halt_post));

  p_halt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !resume) |=> halted);

  p_resume_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && resume) |=> !halted);

  p_run_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && !halt_pre && !halt_post) |=> !halted);

  p_commit_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_b |-> commit_a);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_vld |-> (!commit_a && !commit_b && !halt_pre && !halt_post));
endmodule

bind dual_brk_resolver dbr_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .issue_vld  (issue_vld),
  .issue_solo (issue_solo),
  .resume     (resume),
  .halt_pre   (halt_pre),
  .halt_post  (halt_post),
  .commit_a   (commit_a),
  .commit_b   (commit_b),
  .halted     (halted)
);

// File: tb/dual_brk_resolver_test.sv
module dual_brk_resolver_test;
  logic clk = 1'b0;
  logic rst_n;
  logic issue_vld, issue_solo, brk_pre_a, brk_post_a, brk_pre_b, brk_post_b, resume;
  logic halt_pre, halt_post, commit_a, commit_b, halted;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  dual_brk_resolver uut (
    .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .issue_solo(issue_solo),
    .brk_pre_a(brk_pre_a), .brk_post_a(brk_post_a),
    .brk_pre_b(brk_pre_b), .brk_post_b(brk_post_b), .resume(resume),
    .halt_pre(halt_pre), .halt_post(halt_post),
    .commit_a(commit_a), .commit_b(commit_b), .halted(halted)
  );

  task automatic chk(input string tag, input logic [4:0] got, input logic [4:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b (halted,pre,post,ca,cb)", tag, got, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {halted, halt_pre, halt_post, commit_a, commit_b};
  endfunction

  // expected {pre,post,ca,cb} from the rule table; f = {post_b,pre_b,post_a,pre_a}
  function automatic logic [3:0] model(input bit solo, input logic [3:0] f, input bit sk);
    logic ma, pre;
    ma = f[0] & ~sk;
    if (solo) return {ma, f[1] & ~ma, ~ma, 1'b0};
    if (sk && f[2]) return {1'b1, f[1], 1'b1, 1'b0};
    pre = ma | f[2];
    return {pre, f[1] | f[3], ~pre, ~pre};
  endfunction

  function automatic string tag_of(input bit solo, input logic [3:0] f, input bit sk);
    if (solo) return "R5";
    if (sk && f[2]) return "R9";
    if (sk) return "R8";
    if ((f[0] | f[2]) && (f[1] | f[3])) return "R4";
    if (f[0] | f[2]) return "R2";
    return "R3";
  endfunction

  task automatic drive(input bit v, input bit solo, input logic [3:0] f);
    issue_vld = v; issue_solo = solo;
    {brk_post_b, brk_pre_b, brk_post_a, brk_pre_a} = f;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; resume = 1'b0; drive(1'b0, 1'b0, 4'h0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 chk("R1", outs(), 5'b00000);
  endtask

  initial begin
    logic [3:0] e;
    bit sk;
    do_reset();
    // R7: resume while running leaves no mask behind
    @(negedge clk); resume = 1'b1;
    @(negedge clk); resume = 1'b0; drive(1'b1, 1'b1, 4'b0001);
    #1 chk("R7", outs(), 5'b01000);
    @(negedge clk); drive(1'b0, 1'b0, 4'h0);
    #1 chk("R6", outs(), 5'b10000);

    for (int s = 0; s < 2; s++) begin
      for (int f = 0; f < 16; f++) begin
        do_reset();
        // R10: flags present without issue_vld do nothing
        @(negedge clk); drive(1'b0, s[0], f[3:0]);
        #1 chk("R10", outs(), 5'b00000);
        sk = 1'b0;
        for (int r = 0; r < 4; r++) begin
          @(negedge clk); drive(1'b1, s[0], f[3:0]);
          e = model(s[0], f[3:0], sk);
          #1 chk(tag_of(s[0], f[3:0], sk), outs(), {1'b0, e});
          @(negedge clk); drive(1'b0, s[0], 4'h0);
          #1 chk("R6", {4'b0, halted}, {4'b0, e[3] | e[2]});
          if (halted) begin
            // R6: an issue while halted is ignored
            drive(1'b1, s[0], f[3:0]);
            #1 chk("R6", outs(), 5'b10000);
            @(negedge clk); drive(1'b0, s[0], 4'h0); resume = 1'b1;
            @(negedge clk); resume = 1'b0;
            #1 chk("R7", {4'b0, halted}, 5'b00000);
            sk = e[3];
          end else begin
            sk = 1'b0;
          end
        end
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1 got=timeout exp=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule